// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This block is the digital control for one H-bridge winding. It regulates winding current by chopping with a fixed off-time. When the block is enabled and no fault is present, it drives a diagonal pair of switches: the high-side switch on one leg and the low-side switch on the opposite leg. The direction input selects which diagonal pair is used. When the external current-sense comparator reports that the current has reached its limit, the high-side switch opens. The low-side switch stays closed, so the winding current recirculates through the low side for a fixed number of clock cycles. After that, conduction restarts on its own.

Switching edges cause recovery and capacitive spikes that can make the comparator fire falsely. For this reason the comparator is ignored for a blanking window at the start of every on-phase. A direction change opens all four switches for a dead-time before the other diagonal is driven. Over-temperature, low gate supply, power-up undervoltage and a low enable all force every switch open and return the controller to idle. A status output is high during each off-time, so chopping events can be observed.

Top module: `toff_chopper`

## Requirements
- R1: While reset is high, and on the first cycle after it, all four gate outputs and `off_phase_o` are 0.
- R2: During an on-phase with direction 0, `hs_a_o` and `ls_b_o` are 1 and the other two gates are 0. With direction 1, `hs_b_o` and `ls_a_o` are 1 and the other two gates are 0.
- R3: If the comparator is high once blanking has ended, the next cycle shows the high-side gate at 0 and the diagonal low-side gate still at 1.
- R4: The off-time lasts exactly OFF_CYC cycles. The on-phase then resumes with the same diagonal pair.
- R5: The comparator is ignored for the first BLANK_CYC cycles of every on-phase. With the comparator held high, each on-phase lasts BLANK_CYC+1 cycles.
- R6: A direction change during an on-phase or an off-time opens all four switches on the next cycle, for DEAD_CYC cycles. The new diagonal pair is then driven.
- R7: After an enable from idle, the first on-phase begins DEAD_CYC+1 cycles after the enabling edge.
- R8: Over-temperature or low gate supply opens all gates on the next cycle. They stay open while the fault persists. After the fault clears, restart follows R7.
- R9: Undervoltage lockout behaves exactly like the faults in R8.
- R10: A low enable opens all gates and clears `off_phase_o` on the next cycle. It also clears the timers, so a later enable gets a full dead-time and a full blanking window.
- R11: `hs_a_o` and `ls_a_o` are never both 1, and neither are `hs_b_o` and `ls_b_o`.
- R12: `off_phase_o` is 1 exactly during off-time cycles. In those cycles only one low-side gate is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Chopper enable |
| dir_i | input | 1 | Direction; selects the diagonal pair |
| trip_i | input | 1 | Current-sense comparator output, high at limit |
| ovt_i | input | 1 | Over-temperature fault |
| gsup_low_i | input | 1 | Gate supply too low |
| uvlo_i | input | 1 | Power-up undervoltage lockout |
| hs_a_o | output | 1 | High-side gate, leg A |
| ls_a_o | output | 1 | Low-side gate, leg A |
| hs_b_o | output | 1 | High-side gate, leg B |
| ls_b_o | output | 1 | Low-side gate, leg B |
| off_phase_o | output | 1 | High during the fixed off-time |

## Verification
The bench holds the comparator high from the first cycle of an on-phase. This checks that the on-phase is exactly one cycle longer than the blanking window: a design with no blanking would chop at once, and an off-by-one counter would chop a cycle early or late. It measures the off-time and the dead-time to the exact cycle. It flips direction during an on-phase to catch a design that jumps straight to the other diagonal and shorts a leg. It drops enable during an off-time and then re-enables, to catch stale timer state that would shorten the next dead-time or blanking window. Random stimulus with rare faults and direction flips is compared cycle by cycle against a bench model.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } chop_state_t;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_t;

  localparam gate_t GATES_OPEN = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

endpackage

// File: rtl/chop_timer.sv
// Loadable down-counter; zero_o marks expiry.
module chop_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= load_val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/chop_gate_map.sv
// Maps controller state and direction onto the four bridge gates.
module chop_gate_map
  import chop_pkg::*;
(
  input  chop_state_t st_i,
  input  logic        dir_i,
  output gate_t       gates_o
);

  always_comb begin
    gates_o = GATES_OPEN;
    unique case (st_i)
      ST_ON: begin
        if (dir_i) begin
          gates_o.hs_b = 1'b1;
          gates_o.ls_a = 1'b1;
        end else begin
          gates_o.hs_a = 1'b1;
          gates_o.ls_b = 1'b1;
        end
      end
      ST_OFF: begin
        if (dir_i) gates_o.ls_a = 1'b1;
        else       gates_o.ls_b = 1'b1;
      end
      default: gates_o = GATES_OPEN;
    endcase
  end

endmodule

// File: rtl/toff_chopper.sv
module toff_chopper
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 1500,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned DEAD_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic dir_i,
  input  logic trip_i,
  input  logic ovt_i,
  input  logic gsup_low_i,
  input  logic uvlo_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o,
  output logic off_phase_o
);

  localparam int unsigned TMAX = (OFF_CYC > DEAD_CYC) ? OFF_CYC : DEAD_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned BW   = $clog2(BLANK_CYC + 1);

  chop_state_t st, nxt;
  logic        cur_dir, dir_nxt;
  logic        active;
  logic        tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic        blk_load, blk_zero;
  gate_t       gate_nxt;

  assign active = en_i && !ovt_i && !gsup_low_i && !uvlo_i;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = TW'(DEAD_CYC - 1);
    blk_load = 1'b0;
    if (!active) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          nxt      = ST_DEAD;
          tmr_load = 1'b1;
        end
        ST_DEAD: begin
          if (tmr_zero) begin
            nxt      = ST_ON;
            blk_load = 1'b1;
          end
        end
        ST_ON: begin
          if (dir_i != cur_dir) begin
            nxt      = ST_DEAD;
            tmr_load = 1'b1;
          end else if (blk_zero && trip_i) begin
            nxt      = ST_OFF;
            tmr_load = 1'b1;
            tmr_val  = TW'(OFF_CYC - 1);
            blk_load = 1'b1;
          end
        end
        ST_OFF: begin
          if (dir_i != cur_dir) begin
            nxt      = ST_DEAD;
            tmr_load = 1'b1;
          end else if (tmr_zero) begin
            nxt      = ST_ON;
            blk_load = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign dir_nxt = (nxt == ST_DEAD) ? dir_i : cur_dir;

  chop_timer #(.W(TW)) i_period_tmr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (!active),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  chop_timer #(.W(BW)) i_blank_tmr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (!active),
    .load_i     (blk_load),
    .load_val_i (BW'(BLANK_CYC)),
    .zero_o     (blk_zero)
  );

  chop_gate_map i_gate_map (
    .st_i    (nxt),
    .dir_i   (dir_nxt),
    .gates_o (gate_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cur_dir     <= 1'b0;
      hs_a_o      <= 1'b0;
      ls_a_o      <= 1'b0;
      hs_b_o      <= 1'b0;
      ls_b_o      <= 1'b0;
      off_phase_o <= 1'b0;
    end else begin
      st          <= nxt;
      cur_dir     <= dir_nxt;
      hs_a_o      <= gate_nxt.hs_a;
      ls_a_o      <= gate_nxt.ls_a;
      hs_b_o      <= gate_nxt.hs_b;
      ls_b_o      <= gate_nxt.ls_b;
      off_phase_o <= (nxt == ST_OFF);
    end
  end

  a_r11_leg_a_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hs_a_o && ls_a_o));
  a_r11_leg_b_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hs_b_o && ls_b_o));
  a_r12_off_gates: assert property (@(posedge clk) disable iff (rst)
    off_phase_o |-> (!hs_a_o && !hs_b_o && (ls_a_o != ls_b_o)));
  a_r8_fault_opens: assert property (@(posedge clk) disable iff (rst)
    (ovt_i || gsup_low_i) |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
  a_r9_uvlo_opens: assert property (@(posedge clk) disable iff (rst)
    uvlo_i |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
  a_r10_disable_opens: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o || off_phase_o));
  a_r6_flip_opens: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_ON || st == ST_OFF) && dir_i != cur_dir)
      |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
  a_r3_trip_cuts_high: assert property (@(posedge clk) disable iff (rst)
    (active && st == ST_ON && blk_zero && trip_i && dir_i == cur_dir)
      |=> (off_phase_o && !hs_a_o && !hs_b_o));
  a_r5_blank_masks: assert property (@(posedge clk) disable iff (rst)
    (active && st == ST_ON && !blk_zero && dir_i == cur_dir) |=> (st == ST_ON));

endmodule

// File: tb/test_toff_chopper.sv
module test_toff_chopper;

  localparam int OFF_CYC   = 60;
  localparam int BLANK_CYC = 5;
  localparam int DEAD_CYC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, dir_i = 1'b0, trip_i = 1'b0;
  logic ovt_i = 1'b0, gsup_low_i = 1'b0, uvlo_i = 1'b0;
  logic hs_a_o, ls_a_o, hs_b_o, ls_b_o, off_phase_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  toff_chopper #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .DEAD_CYC(DEAD_CYC)) i_toff_chopper (
    .clk(clk), .rst(rst), .en_i(en_i), .dir_i(dir_i), .trip_i(trip_i),
    .ovt_i(ovt_i), .gsup_low_i(gsup_low_i), .uvlo_i(uvlo_i),
    .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o),
    .off_phase_o(off_phase_o));

  // Bench reference model: 0 idle, 1 dead, 2 on, 3 off
  int m_st = 0;
  int m_cnt = 0;
  bit m_dir = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst || !(en_i && !ovt_i && !gsup_low_i && !uvlo_i)) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_dir = dir_i; m_cnt = 0; end
        1: if (m_cnt == DEAD_CYC - 1) begin m_st = 2; m_cnt = 0; end
           else begin m_dir = dir_i; m_cnt++; end
        2: if (dir_i != m_dir) begin m_st = 1; m_dir = dir_i; m_cnt = 0; end
           else if (m_cnt >= BLANK_CYC && trip_i) begin m_st = 3; m_cnt = 0; end
           else m_cnt++;
        default: if (dir_i != m_dir) begin m_st = 1; m_dir = dir_i; m_cnt = 0; end
           else if (m_cnt == OFF_CYC - 1) begin m_st = 2; m_cnt = 0; end
           else m_cnt++;
      endcase
    end
  end

  function automatic logic [3:0] exp_gates(int st, bit d);
    // order: hs_a, ls_a, hs_b, ls_b
    if (st == 2) return d ? 4'b0110 : 4'b1001;
    if (st == 3) return d ? 4'b0100 : 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [3:0] act_gates();
    return {hs_a_o, ls_a_o, hs_b_o, ls_b_o};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(act_gates() == exp_gates(m_st, m_dir), "R2 model gates",
            int'(act_gates()), int'(exp_gates(m_st, m_dir)));
      check(off_phase_o == (m_st == 3), "R12 model status",
            int'(off_phase_o), int'(m_st == 3));
      check(!(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o), "R11 leg exclusive",
            int'(act_gates()), 0);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count edges until gates become nonzero
  task automatic edges_to_on(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (act_gates() == 4'b0 && n < 1000);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c0de));
    tick(3);
    check(act_gates() == 0 && !off_phase_o, "R1 in reset", int'(act_gates()), 0);
    rst = 1'b0;
    tick(1);
    check(act_gates() == 0 && !off_phase_o, "R1 after reset", int'(act_gates()), 0);

    // R7 start-up dead-time, R2 direction 0 pair
    en_i = 1'b1; dir_i = 1'b0;
    edges_to_on(n);
    check(n == DEAD_CYC + 1, "R7 start delay", n, DEAD_CYC + 1);
    check(act_gates() == 4'b1001, "R2 dir0 pair", int'(act_gates()), 4'b1001);

    // R5 blanking, R3 trip response, R4 off length
    trip_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!off_phase_o && n < 1000);
    check(n == BLANK_CYC + 1, "R5 blank length", n, BLANK_CYC + 1);
    check(act_gates() == 4'b0001, "R3 high side cut", int'(act_gates()), 4'b0001);
    trip_i = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (off_phase_o && n < 1000);
    check(n == OFF_CYC, "R4 off length", n, OFF_CYC);
    check(act_gates() == 4'b1001, "R4 resume pair", int'(act_gates()), 4'b1001);

    // R6 direction flip
    tick(2);
    dir_i = 1'b1;
    @(negedge clk);
    check(act_gates() == 0, "R6 flip opens", int'(act_gates()), 0);
    n = 1;
    while (act_gates() == 0 && n < 1000) begin @(negedge clk); n++; end
    check(n == DEAD_CYC + 1, "R6 dead length", n, DEAD_CYC + 1);
    check(act_gates() == 4'b0110, "R2 dir1 pair", int'(act_gates()), 4'b0110);

    // R8 over-temperature and low gate supply
    ovt_i = 1'b1;
    tick(1);
    check(act_gates() == 0, "R8 ovt opens", int'(act_gates()), 0);
    tick(10);
    check(act_gates() == 0, "R8 ovt holds", int'(act_gates()), 0);
    ovt_i = 1'b0; gsup_low_i = 1'b1;
    tick(5);
    check(act_gates() == 0, "R8 gate supply holds", int'(act_gates()), 0);
    gsup_low_i = 1'b0;
    edges_to_on(n);
    check(n == DEAD_CYC + 1, "R8 restart delay", n, DEAD_CYC + 1);

    // R9 undervoltage lockout
    uvlo_i = 1'b1;
    tick(1);
    check(act_gates() == 0, "R9 uvlo opens", int'(act_gates()), 0);
    tick(8);
    check(act_gates() == 0, "R9 uvlo holds", int'(act_gates()), 0);
    uvlo_i = 1'b0;
    edges_to_on(n);
    check(n == DEAD_CYC + 1, "R9 restart delay", n, DEAD_CYC + 1);

    // R10 disable during off-time clears timers
    trip_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!off_phase_o && n < 1000);
    trip_i = 1'b0;
    tick(3);
    en_i = 1'b0;
    tick(1);
    check(act_gates() == 0 && !off_phase_o, "R10 disable opens",
          int'({off_phase_o, act_gates()}), 0);
    tick(4);
    en_i = 1'b1; trip_i = 1'b1;
    edges_to_on(n);
    check(n == DEAD_CYC + 1, "R10 full dead after re-enable", n, DEAD_CYC + 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!off_phase_o && n < 1000);
    check(n == BLANK_CYC + 1, "R10 full blank after re-enable", n, BLANK_CYC + 1);
    trip_i = 1'b0;

    // Random phase, checked by the model every cycle (R2, R3, R4, R11, R12)
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      en_i       = ($urandom % 400) != 0 ? 1'b1 : (($urandom % 4) != 0 ? 1'b0 : en_i);
      if (($urandom % 250) == 0) dir_i = ~dir_i;
      trip_i     = ($urandom % 6) == 0;
      ovt_i      = ($urandom % 1500) == 0;
      gsup_low_i = ($urandom % 1500) == 0;
      uvlo_i     = ($urandom % 2000) == 0;
    end
    @(negedge clk);
    finish_run();
  end

endmodule